// File: doc/BRIEF.md
# Load/Store Alignment and Lane Extension Unit

This unit sits between a pipeline's execute stage and a data memory port. It accepts one memory operation at a time. Each operation carries an operation code, a 32-bit base register value, a 16-bit displacement and, for stores, a 32-bit source value. The unit adds the sign-extended displacement to the base to form the effective address, then checks that the address is naturally aligned for the access size.

An aligned store goes to memory as a word-aligned address, a 4-bit lane-enable mask and write data with the stored value copied into every lane. An aligned load goes to memory as a read. The returned word is then narrowed to the addressed byte or halfword and widened back to 32 bits, with either sign or zero fill. A misaligned access never reaches the memory port. Instead the unit raises a one-cycle fault and presents the offending effective address to the handler.

The unit has two valid/ready streams and one response input. On the request stream (`req_*`), the unit takes an operation only while `req_ready` is high, and `req_ready` is high only while no operation is in flight. On the memory request stream (`mem_*`), once `mem_valid` rises, the address, write flag, lane mask and write data hold steady until a cycle in which `mem_ready` is high. The memory answers a read by pulsing `mem_rsp_valid` with `mem_rsp_data` and must not answer a write. On the load result stream (`ld_*`), `ld_valid` and `ld_data` hold until `ld_ready` is seen high.

Top module: `lsu_align_ext`

## Requirements
- R1: The effective address equals `req_base` plus the sign-extended `req_disp`, modulo 2^32, with no overflow indication. `mem_addr` carries this address with bits [1:0] cleared, and `fault_addr` carries all 32 bits of it.
- R2: The fields of `req_op` are as follows. Bit 3 is 1 for a store. Bit 2 is 1 for zero-extending loads. Bits [1:0] give the size: 0 is byte, 1 is halfword, 2 is word, and 3 is treated as word. A word access with address bits [1:0] not 00, or a halfword access with address bit 0 set, is misaligned. A byte access is never misaligned.
- R3: A misaligned access raises `align_fault` for exactly one cycle, starting in the cycle after acceptance. During that cycle `fault_addr` equals the effective address. The access never raises `mem_valid` or `ld_valid`, and it leaves memory contents unchanged.
- R4: For a store, `mem_be` is 0001 shifted left by address bits [1:0] for a byte, 0011 shifted by those bits for a halfword, and 1111 for a word. Lanes are little-endian: lane 0 is data bits [7:0]. `mem_be` is 0000 whenever no store request is presented.
- R5: For a store, every lane of `mem_wdata` carries the source's low byte for a byte store, every halfword carries the source's low halfword for a halfword store, and the full source goes out for a word store.
- R6: For a signed load, the result is the addressed lane(s) of the returned word, little-endian, with the top bit of the loaded byte or halfword copied into all upper bits.
- R7: For an unsigned load, the result is the addressed byte or halfword with zeros in all upper bits.
- R8: `req_ready` is high only when no operation is in flight. `mem_valid` rises in the cycle after an aligned operation is accepted. While `mem_valid` is high and `mem_ready` is low, the memory request outputs hold steady. `mem_we` equals the store bit. A store completes at the memory handshake.
- R9: `ld_valid` rises in the cycle after `mem_rsp_valid`. It holds, together with a steady `ld_data`, until `ld_ready` is high, and then the unit returns to accepting requests.
- R10: After reset, `req_ready` is 1 and `mem_valid`, `ld_valid`, `align_fault` and `mem_be` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Operation offered |
| req_ready | output | 1 | Unit idle, operation taken this cycle if valid |
| req_op | input | 4 | Store flag, unsigned flag, size |
| req_base | input | 32 | Base register value |
| req_disp | input | 16 | Signed displacement |
| req_src | input | 32 | Store source value |
| mem_valid | output | 1 | Memory request presented |
| mem_ready | input | 1 | Memory takes request |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_we | output | 1 | Write request |
| mem_be | output | 4 | Lane enables for writes |
| mem_wdata | output | 32 | Lane-replicated write data |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Returned word |
| ld_valid | output | 1 | Load result presented |
| ld_ready | input | 1 | Consumer takes load result |
| ld_data | output | 32 | Extended load result |
| align_fault | output | 1 | Misalignment fault pulse |
| fault_addr | output | 32 | Faulting effective address |

## Verification
The hardest case to reach is proving that a misaligned store left memory untouched, because a suppressed write has no direct port signature beyond the missing handshake. The stimulus issues faulting word and halfword stores at an address that already holds a known word. It then reads that word back with an aligned load and compares it with the bench's own memory image. Negative displacements and a base near the top of the address space drive the adder through borrow and wrap, and stalls on both the memory and the result streams exercise the hold rules.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } acc_size_e;

  typedef struct packed {
    logic      is_store;
    logic      zero_ext;
    acc_size_e size;
  } mem_op_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_RESP,
    ST_FAULT
  } lsu_state_e;

endpackage

// File: rtl/lsu_ea_check.sv
module lsu_ea_check
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16,
  parameter int NB     = 4
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [DISP_W-1:0] disp,
  input  acc_size_e         size,
  output logic [ADDR_W-1:0] ea,
  output logic              misalign
);
  localparam int LANE_BITS = $clog2(NB);
  localparam int EXT_W     = ADDR_W - DISP_W;

  logic [LANE_BITS-1:0] need_zero;

  // Displacement widened by sign, sum wraps silently.
  assign ea = base + {{EXT_W{disp[DISP_W-1]}}, disp};

  always_comb begin
    case (size)
      SZ_BYTE: need_zero = '0;
      SZ_HALF: need_zero = LANE_BITS'(1);
      default: need_zero = LANE_BITS'(NB - 1);
    endcase
  end

  assign misalign = |(ea[LANE_BITS-1:0] & need_zero);

endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  acc_size_e                       size,
  input  logic [$clog2(DATA_W/8)-1:0]     off,
  input  logic [DATA_W-1:0]               src,
  output logic [DATA_W/8-1:0]             be,
  output logic [DATA_W-1:0]               wdata
);
  localparam int NB        = DATA_W / 8;
  localparam int LANE_BITS = $clog2(NB);

  logic [LANE_BITS:0]   nbytes;
  logic [LANE_BITS-1:0] wrap_mask;
  logic [LANE_BITS:0]   lo;
  logic [LANE_BITS:0]   hi;

  always_comb begin
    case (size)
      SZ_BYTE: nbytes = (LANE_BITS+1)'(1);
      SZ_HALF: nbytes = (LANE_BITS+1)'(2);
      default: nbytes = (LANE_BITS+1)'(NB);
    endcase
  end

  assign wrap_mask = LANE_BITS'(nbytes - (LANE_BITS+1)'(1));
  assign lo        = {1'b0, off};
  assign hi        = lo + nbytes;

  for (genvar i = 0; i < NB; i++) begin : g_lane
    localparam logic [LANE_BITS:0] LANE = (LANE_BITS+1)'(i);
    logic [LANE_BITS-1:0] pick;
    assign pick  = LANE[LANE_BITS-1:0] & wrap_mask;
    assign be[i] = (LANE >= lo) && (LANE < hi);
    assign wdata[i*8 +: 8] = src[{pick, 3'b000} +: 8];
  end

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  acc_size_e                   size,
  input  logic                        zero_ext,
  input  logic [$clog2(DATA_W/8)-1:0] off,
  input  logic [DATA_W-1:0]           word,
  output logic [DATA_W-1:0]           result
);
  logic [DATA_W-1:0] shifted;
  logic              top_bit;
  logic              fill;

  assign shifted = word >> {off, 3'b000};

  always_comb begin
    case (size)
      SZ_BYTE: top_bit = shifted[7];
      SZ_HALF: top_bit = shifted[15];
      default: top_bit = shifted[DATA_W-1];
    endcase
  end

  assign fill = top_bit & ~zero_ext;

  always_comb begin
    for (int j = 0; j < DATA_W; j++) begin
      case (size)
        SZ_BYTE: result[j] = (j < 8)  ? shifted[j] : fill;
        SZ_HALF: result[j] = (j < 16) ? shifted[j] : fill;
        default: result[j] = shifted[j];
      endcase
    end
  end

endmodule

// File: rtl/lsu_align_ext.sv
module lsu_align_ext
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DISP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [3:0]        req_op,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [DISP_W-1:0] req_disp,
  input  logic [DATA_W-1:0] req_src,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W/8-1:0] mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              ld_valid,
  input  logic              ld_ready,
  output logic [DATA_W-1:0] ld_data,
  output logic              align_fault,
  output logic [ADDR_W-1:0] fault_addr
);
  localparam int NB        = DATA_W / 8;
  localparam int LANE_BITS = $clog2(NB);

  lsu_state_e        state;
  mem_op_t           op_in;
  mem_op_t           op_q;
  logic [ADDR_W-1:0] ea_c;
  logic [ADDR_W-1:0] ea_q;
  logic              misalign_c;
  logic [DATA_W-1:0] src_q;
  logic [DATA_W-1:0] ld_q;
  logic [NB-1:0]     be_c;
  logic [DATA_W-1:0] wdata_c;
  logic [DATA_W-1:0] ext_c;

  assign op_in = mem_op_t'(req_op);

  lsu_ea_check #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .NB(NB)) u_ea (
    .base     (req_base),
    .disp     (req_disp),
    .size     (op_in.size),
    .ea       (ea_c),
    .misalign (misalign_c)
  );

  lsu_store_lanes #(.DATA_W(DATA_W)) u_st (
    .size  (op_q.size),
    .off   (ea_q[LANE_BITS-1:0]),
    .src   (src_q),
    .be    (be_c),
    .wdata (wdata_c)
  );

  lsu_load_extract #(.DATA_W(DATA_W)) u_ld (
    .size     (op_q.size),
    .zero_ext (op_q.zero_ext),
    .off      (ea_q[LANE_BITS-1:0]),
    .word     (mem_rsp_data),
    .result   (ext_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      op_q  <= '0;
      ea_q  <= '0;
      src_q <= '0;
      ld_q  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          op_q  <= op_in;
          ea_q  <= ea_c;
          src_q <= req_src;
          state <= misalign_c ? ST_FAULT : ST_ISSUE;
        end
        ST_ISSUE: if (mem_ready) state <= op_q.is_store ? ST_IDLE : ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          ld_q  <= ext_c;
          state <= ST_RESP;
        end
        ST_RESP:  if (ld_ready) state <= ST_IDLE;
        ST_FAULT: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready   = (state == ST_IDLE);
  assign mem_valid   = (state == ST_ISSUE);
  assign mem_we      = mem_valid & op_q.is_store;
  assign mem_addr    = {ea_q[ADDR_W-1:LANE_BITS], {LANE_BITS{1'b0}}};
  assign mem_be      = mem_we ? be_c : '0;
  assign mem_wdata   = wdata_c;
  assign ld_valid    = (state == ST_RESP);
  assign ld_data     = ld_q;
  assign align_fault = (state == ST_FAULT);
  assign fault_addr  = align_fault ? ea_q : '0;

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_be) && $stable(mem_wdata)); // R8
  AST_LD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && !ld_ready |=> ld_valid && $stable(ld_data)); // R9
  AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    align_fault |-> !mem_valid && !ld_valid && (mem_be == '0)); // R3
  AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    align_fault |=> !align_fault); // R3
  AST_FAULT_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    align_fault |-> (fault_addr[LANE_BITS-1:0] != '0)); // R2
  AST_BE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($countones(mem_be) == 1) || ($countones(mem_be) == 2) || ($countones(mem_be) == NB)); // R4
  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_valid && !ld_valid && !align_fault); // R8
  AST_RSP_TO_LD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT) && mem_rsp_valid |=> ld_valid); // R9

endmodule

// File: tb/tb_lsu_align_ext.sv
module tb_lsu_align_ext;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_op = '0;
  logic [31:0] req_base = '0;
  logic [15:0] req_disp = '0;
  logic [31:0] req_src = '0;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_addr;
  logic        mem_we;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        ld_valid;
  logic        ld_ready = 1'b0;
  logic [31:0] ld_data;
  logic        align_fault;
  logic [31:0] fault_addr;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [31:0] image [16];

  always #10 clk = ~clk;

  lsu_align_ext dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // every-clock invariants
  always @(negedge clk) if (rst_n && !finished) begin
    if (align_fault) chk(mem_be == 4'h0 && !mem_valid, "R3", {28'h0, mem_be}, 32'h0);
    if (!(mem_valid && mem_we)) chk(mem_be == 4'h0, "R4", {28'h0, mem_be}, 32'h0);
  end

  task automatic run_op(input logic [3:0] k, input logic [31:0] base, input logic [15:0] disp,
                        input logic [31:0] src, input int mstall, input int lstall);
    logic [31:0] ea, exp_w, exp_d, sh;
    logic [3:0]  exp_be;
    logic [1:0]  sz;
    bit          flt;
    int          idx;
    string       tag;
    ea  = base + {{16{disp[15]}}, disp};
    sz  = k[1:0];
    flt = ((sz == 2'd2 || sz == 2'd3) && ea[1:0] != 2'b00) || (sz == 2'd1 && ea[0]);
    idx = int'(ea[5:2]);
    case (sz)
      2'd0: begin exp_be = 4'b0001 << ea[1:0]; exp_w = {4{src[7:0]}}; end
      2'd1: begin exp_be = 4'b0011 << ea[1:0]; exp_w = {2{src[15:0]}}; end
      default: begin exp_be = 4'b1111; exp_w = src; end
    endcase
    @(negedge clk);
    chk(req_ready, "R8", {31'h0, req_ready}, 32'h1);
    req_valid = 1'b1; req_op = k; req_base = base; req_disp = disp; req_src = src;
    @(negedge clk);
    req_valid = 1'b0;
    if (flt) begin
      chk(align_fault, "R3", {31'h0, align_fault}, 32'h1);
      chk(fault_addr == ea, "R1", fault_addr, ea);
      chk(!mem_valid && !ld_valid, "R3", {30'h0, mem_valid, ld_valid}, 32'h0);
      @(negedge clk);
      chk(!align_fault && req_ready && !mem_valid, "R3", {29'h0, align_fault, req_ready, mem_valid}, 32'h2);
      return;
    end
    chk(!align_fault, "R2", {31'h0, align_fault}, 32'h0);
    for (int s = 0; s < mstall; s++) begin
      chk(mem_valid, "R8", {31'h0, mem_valid}, 32'h1);
      @(negedge clk);
    end
    chk(mem_valid, "R8", {31'h0, mem_valid}, 32'h1);
    chk(mem_addr == {ea[31:2], 2'b00}, "R1", mem_addr, {ea[31:2], 2'b00});
    chk(mem_we == k[3], "R8", {31'h0, mem_we}, {31'h0, k[3]});
    if (k[3]) begin
      chk(mem_be == exp_be, "R4", {28'h0, mem_be}, {28'h0, exp_be});
      chk(mem_wdata == exp_w, "R5", mem_wdata, exp_w);
    end
    mem_ready = 1'b1;
    @(negedge clk);
    mem_ready = 1'b0;
    if (k[3]) begin
      for (int b = 0; b < 4; b++) if (exp_be[b]) image[idx][b*8 +: 8] = exp_w[b*8 +: 8];
      chk(req_ready && !mem_valid, "R8", {30'h0, req_ready, mem_valid}, 32'h2);
      return;
    end
    chk(!ld_valid, "R9", {31'h0, ld_valid}, 32'h0);
    mem_rsp_valid = 1'b1; mem_rsp_data = image[idx];
    @(negedge clk);
    mem_rsp_valid = 1'b0; mem_rsp_data = 32'hDEAD_BEEF;
    sh  = image[idx] >> (8 * int'(ea[1:0]));
    tag = k[2] ? "R7" : "R6";
    case (sz)
      2'd0: exp_d = k[2] ? {24'h0, sh[7:0]} : {{24{sh[7]}}, sh[7:0]};
      2'd1: exp_d = k[2] ? {16'h0, sh[15:0]} : {{16{sh[15]}}, sh[15:0]};
      default: exp_d = sh;
    endcase
    for (int s = 0; s < lstall; s++) begin
      chk(ld_valid && ld_data == exp_d, "R9", ld_data, exp_d);
      @(negedge clk);
    end
    chk(ld_valid, "R9", {31'h0, ld_valid}, 32'h1);
    chk(ld_data == exp_d, tag, ld_data, exp_d);
    ld_ready = 1'b1;
    @(negedge clk);
    ld_ready = 1'b0;
    chk(!ld_valid && req_ready, "R9", {30'h0, ld_valid, req_ready}, 32'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) image[i] = 32'h5A3C_96E1 ^ (32'h0101_0101 * i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(req_ready && !mem_valid && !ld_valid && !align_fault && mem_be == 4'h0, "R10",
        {27'h0, req_ready, mem_valid, ld_valid, align_fault, |mem_be}, 32'h10);
    // stores of each width (R4, R5)
    run_op(4'b1010, 32'h0000_1000, 16'h0000, 32'h1122_3344, 0, 0);
    run_op(4'b1001, 32'h0000_1000, 16'h0006, 32'hAAAA_8001, 2, 0);
    run_op(4'b1000, 32'h0000_1000, 16'h0009, 32'h1234_56F0, 0, 0);
    run_op(4'b1000, 32'h0000_1000, 16'h000F, 32'h0000_0085, 1, 0);
    run_op(4'b1001, 32'h0000_1000, 16'h000C, 32'h0000_7FFE, 0, 0);
    // loads, signed R6 and unsigned R7
    run_op(4'b0010, 32'h0000_1000, 16'h0000, 32'h0, 0, 0);
    run_op(4'b0001, 32'h0000_1000, 16'h0006, 32'h0, 0, 3);
    run_op(4'b0101, 32'h0000_1000, 16'h0006, 32'h0, 1, 0);
    run_op(4'b0000, 32'h0000_1000, 16'h0009, 32'h0, 0, 0);
    run_op(4'b0100, 32'h0000_1000, 16'h0009, 32'h0, 0, 1);
    run_op(4'b0000, 32'h0000_1000, 16'h0003, 32'h0, 0, 0);
    run_op(4'b0000, 32'h0000_1000, 16'h000F, 32'h0, 0, 0);
    run_op(4'b0001, 32'h0000_1000, 16'h000C, 32'h0, 0, 0);
    run_op(4'b0001, 32'h0000_1000, 16'h0000, 32'h0, 0, 0);
    run_op(4'b0011, 32'h0000_1000, 16'h0004, 32'h0, 0, 0);
    // R1 negative displacement and wrap-around
    run_op(4'b0010, 32'h0000_1010, 16'hFFF0, 32'h0, 3, 2);
    run_op(4'b1010, 32'hFFFF_FFFC, 16'h0008, 32'hCAFE_F00D, 0, 0);
    run_op(4'b0010, 32'h0000_1000, 16'h0004, 32'h0, 0, 0);
    // R2/R3 faults
    run_op(4'b0010, 32'h0000_1000, 16'h0001, 32'h0, 0, 0);
    run_op(4'b0010, 32'h0000_1000, 16'h0002, 32'h0, 0, 0);
    run_op(4'b0110, 32'h0000_1000, 16'h0003, 32'h0, 0, 0);
    run_op(4'b0001, 32'h0000_1000, 16'h0001, 32'h0, 0, 0);
    run_op(4'b0101, 32'h0000_1000, 16'h0003, 32'h0, 0, 0);
    run_op(4'b0010, 32'h0000_1000, 16'hFFFF, 32'h0, 0, 0);
    run_op(4'b1010, 32'h0000_1000, 16'h0002, 32'hFFFF_FFFF, 0, 0);
    run_op(4'b1001, 32'h0000_1000, 16'h0005, 32'hFFFF_FFFF, 0, 0);
    run_op(4'b1011, 32'h0000_1000, 16'h0001, 32'hFFFF_FFFF, 0, 0);
    // R3 memory untouched by faulting stores
    run_op(4'b0010, 32'h0000_1000, 16'h0000, 32'h0, 0, 0);
    run_op(4'b0010, 32'h0000_1000, 16'h0004, 32'h0, 0, 0);
    // R2 byte access at odd address never faults
    run_op(4'b1000, 32'h0000_1000, 16'h0007, 32'h0000_0099, 0, 0);
    run_op(4'b0100, 32'h0000_1000, 16'h0007, 32'h0, 0, 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule